// File: doc/BRIEF.md
# Bitfield and Bit-Permute ALU

This block is a purely combinational datapath ALU for a 32-bit core. A 4-bit operation code picks one function of two operands, A and B, and the 32-bit result appears on the output in the same cycle. Besides the usual add, subtract, logic and shift functions, it offers a rotate right, an append step that builds wide constants 10 bits at a time, a bitfield insert, signed and unsigned bitfield extraction, and a staged bit permutation ("flip") that swaps neighbouring groups of bits.

The bitfield functions take their geometry from operand B. The field start bit sits in B[4:0] and the field width in B[8:5], where a width code of zero stands for a 16-bit field. For insert, the value to be placed is B shifted right by 10, so one operand carries both the data and its position. Choosing between a register and an immediate for B, the register file and condition flags all live outside this block. The caller sign-extends any immediate before it reaches B.

Top module: `alu_bitfield_core`

## Requirements
- R1: Code 0 gives A+B and code 2 gives A-B, both modulo 2^32.
- R2: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B and code 7 gives the complement of A XOR B.
- R3: Code 1 rotates A right by B modulo 32. Bit i of the result is A[(i + B mod 32) mod 32], and every higher bit of B is ignored.
- R4: Code 8 shifts A left, code 9 shifts it right logically and code 10 shifts it right arithmetically, each by the full unsigned value of B. Any amount of 32 or more yields zero for codes 8 and 9, and 32 copies of A[31] for code 10.
- R5: Code 3 yields (A shifted left by 10) OR B[9:0].
- R6: For codes 11, 12 and 13 the field position is B[4:0] and the field length is B[8:5], with a length code of 0 meaning 16 bits.
- R7: Code 11 (insert) writes the low "length" bits of B>>10 into A starting at the position. Field bits that would land above bit 31 are dropped, and every other bit of A passes through unchanged.
- R8: Code 13 (unsigned extract) returns (A >> position) masked to its low "length" bits, with zeros above them.
- R9: Code 12 (signed extract) returns the same field as code 13, sign-extended from the field's top bit.
- R10: Code 14 (flip) applies stages 0 to 4 in rising order. Stage k runs when B[k] is set and swaps each adjacent pair of 2^k-bit groups. The net effect is that result bit i equals A[i XOR B[4:0]].
- R11: Code 15 is illegal. It drives illegal_op_o high and the result to zero. illegal_op_o is low for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B: register value or sign-extended immediate |
| result_o | output | 32 | Operation result |
| illegal_op_o | output | 1 | High when the code is illegal |

## Verification
The bench builds the block with its default width of 32 data bits, a 4-bit length code and a 10-bit append step. These defaults allow a 16-bit field at every start position from 0 to 31, so inserts and extracts that run off the top of the word can be tested. They also allow all five flip stages together and shift amounts just below, at and far above 32. Flip and rotate are checked against index formulas rather than staged swaps. Signed extraction is exercised with fields whose top bit is both set and clear.

// File: rtl/alu_bitfield_pkg.sv
package alu_bitfield_pkg;

    localparam int DATA_W    = 32;
    localparam int LEN_W     = 4;
    localparam int APPEND_W  = 10;
    localparam int INS_SHIFT = 10;

    typedef enum logic [3:0] {
        OP_ADD    = 4'h0,
        OP_ROR    = 4'h1,
        OP_SUB    = 4'h2,
        OP_APPEND = 4'h3,
        OP_AND    = 4'h4,
        OP_OR     = 4'h5,
        OP_XOR    = 4'h6,
        OP_XNOR   = 4'h7,
        OP_SHL    = 4'h8,
        OP_SHR    = 4'h9,
        OP_SRA    = 4'hA,
        OP_INSERT = 4'hB,
        OP_SEXT   = 4'hC,
        OP_UEXT   = 4'hD,
        OP_FLIP   = 4'hE,
        OP_BAD    = 4'hF
    } alu_op_e;

    // Field width in bits: a zero code selects the widest field.
    function automatic logic [LEN_W:0] field_len(input logic [LEN_W-1:0] code);
        if (code == '0)
            return (LEN_W+1)'(1 << LEN_W);
        return {1'b0, code};
    endfunction

endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_bitfield_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int AMT_W = $clog2(W)
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] ror_o,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] sra_o,
    output logic [W-1:0] app_o
);

    logic [AMT_W-1:0] amt;
    logic [AMT_W:0]   back_amt;
    logic             too_far;

    assign amt      = b_i[AMT_W-1:0];
    assign too_far  = |b_i[W-1:AMT_W];
    assign back_amt = (AMT_W+1)'(W) - {1'b0, amt};

    always_comb begin
        ror_o = (a_i >> amt) | (a_i << back_amt);
        shl_o = too_far ? '0 : (a_i << amt);
        shr_o = too_far ? '0 : (a_i >> amt);
        sra_o = too_far ? {W{a_i[W-1]}} : W'($signed(a_i) >>> amt);
        app_o = (a_i << APPEND_W) | W'(b_i[APPEND_W-1:0]);
    end

    always_comb begin
        a_r3_rotate_keeps_ones: assert ($countones(ror_o) == $countones(a_i))
            else $error("R3 rotate changed the number of set bits");
        if (too_far) begin
            a_r4_far_shift_clears: assert (shl_o == '0 && shr_o == '0)
                else $error("R4 long logical shift left bits behind");
        end
    end

endmodule

// File: rtl/alu_field_unit.sv
module alu_field_unit
    import alu_bitfield_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     src_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [LEN_W-1:0] len_code_i,
    output logic [W-1:0]     ins_o,
    output logic [W-1:0]     uext_o,
    output logic [W-1:0]     sext_o
);

    logic [LEN_W:0] len;
    logic [W-1:0]   low_mask;
    logic [W-1:0]   top_bit;
    logic [W-1:0]   place_mask;
    logic [W-1:0]   shifted;
    logic           field_neg;

    always_comb begin
        len        = field_len(len_code_i);
        low_mask   = ~({W{1'b1}} << len);
        top_bit    = low_mask ^ (low_mask >> 1);
        place_mask = low_mask << pos_i;
        ins_o      = (a_i & ~place_mask) | ((src_i << pos_i) & place_mask);
        shifted    = a_i >> pos_i;
        uext_o     = shifted & low_mask;
        field_neg  = |(uext_o & top_bit);
        sext_o     = field_neg ? (uext_o | ~low_mask) : uext_o;
    end

    logic [W-1:0] sext_hi;
    always_comb begin
        sext_hi = W'($signed(sext_o) >>> (len - 1'b1));
        a_r7_insert_keeps_rest: assert (((ins_o ^ a_i) & ~place_mask) == '0)
            else $error("R7 insert disturbed bits outside the field");
        a_r8_uext_zero_above: assert ((uext_o >> len) == '0)
            else $error("R8 unsigned extract left bits above the field");
        a_r9_sext_uniform_top: assert (sext_hi == '0 || sext_hi == '1)
            else $error("R9 signed extract upper bits not uniform");
    end

endmodule

// File: rtl/alu_flip_unit.sv
module alu_flip_unit
    import alu_bitfield_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int STAGES = $clog2(W)
) (
    input  logic [W-1:0]      x_i,
    input  logic [STAGES-1:0] sel_i,
    output logic [W-1:0]      y_o
);

    logic [W-1:0] stage [STAGES+1];

    assign stage[0] = x_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int GRP = 1 << k;
        logic [W-1:0] swapped;
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign swapped[i] = stage[k][i ^ GRP];
        end
        assign stage[k+1] = sel_i[k] ? swapped : stage[k];
    end

    assign y_o = stage[STAGES];

    always_comb begin
        a_r10_flip_permutes: assert ($countones(y_o) == $countones(x_i))
            else $error("R10 flip is not a permutation");
    end

endmodule

// File: rtl/alu_bitfield_core.sv
module alu_bitfield_core
    import alu_bitfield_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int POS_W = $clog2(W)
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         illegal_op_o
);

    logic [W-1:0] ror_r, shl_r, shr_r, sra_r, app_r;
    logic [W-1:0] ins_r, uext_r, sext_r, flip_r;
    alu_op_e      op;

    assign op = alu_op_e'(op_i);

    alu_shift_unit #(.W(W)) u_shift (
        .a_i   (a_i),
        .b_i   (b_i),
        .ror_o (ror_r),
        .shl_o (shl_r),
        .shr_o (shr_r),
        .sra_o (sra_r),
        .app_o (app_r)
    );

    alu_field_unit #(.W(W)) u_field (
        .a_i        (a_i),
        .src_i      (b_i >> INS_SHIFT),
        .pos_i      (b_i[POS_W-1:0]),
        .len_code_i (b_i[POS_W +: LEN_W]),
        .ins_o      (ins_r),
        .uext_o     (uext_r),
        .sext_o     (sext_r)
    );

    alu_flip_unit #(.W(W)) u_flip (
        .x_i   (a_i),
        .sel_i (b_i[POS_W-1:0]),
        .y_o   (flip_r)
    );

    always_comb begin
        illegal_op_o = 1'b0;
        unique case (op)
            OP_ADD:    result_o = a_i + b_i;
            OP_ROR:    result_o = ror_r;
            OP_SUB:    result_o = a_i - b_i;
            OP_APPEND: result_o = app_r;
            OP_AND:    result_o = a_i & b_i;
            OP_OR:     result_o = a_i | b_i;
            OP_XOR:    result_o = a_i ^ b_i;
            OP_XNOR:   result_o = ~(a_i ^ b_i);
            OP_SHL:    result_o = shl_r;
            OP_SHR:    result_o = shr_r;
            OP_SRA:    result_o = sra_r;
            OP_INSERT: result_o = ins_r;
            OP_SEXT:   result_o = sext_r;
            OP_UEXT:   result_o = uext_r;
            OP_FLIP:   result_o = flip_r;
            default: begin
                result_o     = '0;
                illegal_op_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (illegal_op_o) begin
            a_r11_illegal_zero: assert (result_o == '0)
                else $error("R11 illegal code produced a nonzero result");
        end
        if (op == OP_ADD) begin
            a_r1_add_inverts: assert (result_o - b_i == a_i)
                else $error("R1 sum minus B does not give A");
        end
    end

endmodule

// File: tb/alu_bitfield_core_tb_top.sv
module alu_bitfield_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op  = 4'h0;
    logic [31:0] a   = '0;
    logic [31:0] b   = '0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alu_bitfield_core dut_i (
        .op_i         (op),
        .a_i          (a),
        .b_i          (b),
        .result_o     (result),
        .illegal_op_o (illegal)
    );

    typedef struct {
        logic [31:0] exp;
        logic        ill;
        string       req;
    } item_t;

    item_t sb[$];

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h2:             return "R1";
            4'h4, 4'h5, 4'h6, 4'h7: return "R2";
            4'h1:                   return "R3";
            4'h8, 4'h9, 4'hA:       return "R4";
            4'h3:                   return "R5";
            4'hB:                   return "R7";
            4'hC:                   return "R9";
            4'hD:                   return "R8";
            4'hE:                   return "R10";
            default:                return "R11";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x,
                                          input logic [31:0] y);
        logic [31:0] r;
        int pos, len, sh;
        logic [31:0] src;
        r   = '0;
        pos = int'(y[4:0]);
        len = (y[8:5] == 0) ? 16 : int'(y[8:5]);
        src = y >> 10;
        case (c)
            4'h0: r = x + y;
            4'h2: r = x - y;
            4'h4: r = x & y;
            4'h5: r = x | y;
            4'h6: r = x ^ y;
            4'h7: r = ~(x ^ y);
            4'h1: for (int i = 0; i < 32; i++) r[i] = x[(i + pos) % 32];
            4'h3: r = {x[21:0], y[9:0]};
            4'h8, 4'h9, 4'hA: begin
                for (int i = 0; i < 32; i++) begin
                    if (c == 4'h8)
                        r[i] = (y < 32 && i - int'(y) >= 0) ? x[i - int'(y)] : 1'b0;
                    else if (y < 32 && i + int'(y) < 32)
                        r[i] = x[i + int'(y)];
                    else
                        r[i] = (c == 4'hA) ? x[31] : 1'b0;
                end
            end
            4'hB: begin
                r = x;
                for (int j = 0; j < len; j++)
                    if (pos + j < 32) r[pos + j] = src[j];
            end
            4'hC, 4'hD: begin
                for (int j = 0; j < len; j++)
                    r[j] = (pos + j < 32) ? x[pos + j] : 1'b0;
                if (c == 4'hC)
                    for (int j = len; j < 32; j++) r[j] = r[len - 1];
            end
            4'hE: for (int i = 0; i < 32; i++) r[i] = x[i ^ pos];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic drive(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        item_t it;
        @(negedge clk);
        op = c;
        a  = x;
        b  = y;
        it.exp = model(c, x, y);
        it.ill = (c == 4'hF);
        it.req = req_of(c);
        sb.push_back(it);
    endtask

    // Monitor: compare one scoreboard item per rising edge.
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (result !== it.exp) begin
                errors++;
                $display("FAIL %s result actual=%h expected=%h (op=%h a=%h b=%h)",
                         it.req, result, it.exp, op, a, b);
            end
            checks++;
            if (illegal !== it.ill) begin
                errors++;
                $display("FAIL R11 illegal_op actual=%b expected=%b (op=%h)",
                         illegal, it.ill, op);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        lf = 32'hACE1_2468;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Reset-state pattern: all-zero inputs give zero, no illegal flag (R1).
        drive(4'h0, 32'h0, 32'h0);
        // R1 wrap-around
        drive(4'h0, 32'hFFFF_FFFF, 32'h0000_0002);
        drive(4'h2, 32'h0000_0001, 32'h0000_0003);
        // R2 logic
        drive(4'h4, 32'hF0F0_1234, 32'h0FF0_FFFF);
        drive(4'h5, 32'hF000_0000, 32'h0000_000F);
        drive(4'h6, 32'hAAAA_5555, 32'hFFFF_0000);
        drive(4'h7, 32'h1234_5678, 32'h1234_5678);
        // R3 rotate: high bits of B ignored
        drive(4'h1, 32'h0000_0001, 32'h0000_0001);
        drive(4'h1, 32'h8765_4321, 32'hFFFF_FF24);
        drive(4'h1, 32'hDEAD_BEEF, 32'h0000_0020);
        // R4 shifts at and past 32
        drive(4'h8, 32'h0000_0003, 32'd31);
        drive(4'h8, 32'hFFFF_FFFF, 32'd32);
        drive(4'h9, 32'h8000_0000, 32'd31);
        drive(4'h9, 32'hFFFF_FFFF, 32'h1000_0000);
        drive(4'hA, 32'h8000_0000, 32'd4);
        drive(4'hA, 32'h8000_0000, 32'd40);
        drive(4'hA, 32'h7FFF_FFFF, 32'd33);
        // R5 append
        drive(4'h3, 32'h0012_3456, 32'hFFFF_FEAB);
        // R6 length code 0 means 16, position B[4:0]
        drive(4'hD, 32'hABCD_1234, {22'h0, 4'h0, 5'd8});
        drive(4'hC, 32'h0000_8000, {22'h0, 4'h0, 5'd0});
        // R7 insert, including field crossing bit 31
        drive(4'hB, 32'hFFFF_FFFF, {22'h0, 4'h4, 5'd4});
        drive(4'hB, 32'h0000_0000, {22'h3FFFFF, 4'h0, 5'd24});
        drive(4'hB, 32'h1234_5678, {22'h2A5, 4'h8, 5'd12});
        // R8/R9 extract, sign set and clear
        drive(4'hD, 32'hF000_0000, {22'h0, 4'h8, 5'd28});
        drive(4'hC, 32'hF000_0000, {22'h0, 4'h8, 5'd28});
        drive(4'hC, 32'h0000_0070, {22'h0, 4'h4, 5'd4});
        drive(4'hC, 32'h0000_0080, {22'h0, 4'h4, 5'd4});
        drive(4'hC, 32'h8000_0000, {22'h0, 4'h1, 5'd31});
        // R10 flip, all stages and single stages
        drive(4'hE, 32'h0000_0001, 32'h0000_001F);
        drive(4'hE, 32'h1234_5678, 32'h0000_0010);
        drive(4'hE, 32'h1234_5678, 32'hFFFF_FFE3);
        // R11 illegal code
        drive(4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // Pseudo-random sweep of every code
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ra = lf * 32'h9E37_79B9;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rb = (n % 3 == 0) ? (lf & 32'h0000_003F) : lf ^ (lf << 7);
            drive(4'(n % 16), ra, rb);
        end
        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule